// File: doc/BRIEF.md
# Register-Skip Byte Processor

This block is a very small 8-bit processor core. It fetches 16-bit instruction words from an external instruction store, addressed by an 8-bit program counter. It executes a seven-operation instruction set against sixteen 8-bit registers. Memory and peripherals sit on one byte-wide data bus, so they are reached by address: the core drives an address, write data and a read or write strobe, and samples read data. The surrounding logic decodes addresses into ROM text, status bytes or transmit registers as it needs.

Register 0 holds the program counter. There is no separate jump instruction: any instruction that writes R0 redirects fetch. Reading R0 as an operand yields the address of the instruction being executed. Conditional flow is built only from compare-and-skip instructions. A taken skip steps the counter by two instead of one.

Every instruction takes exactly two clock cycles. In the fetch cycle the instruction word is captured. In the execute cycle the bus access, if any, is made and the result is written back. The instruction fetch port and the data bus are plain combinational request ports with no handshake. The instruction store and the data responder must answer within the same cycle, because the core never waits.

Top module: `tiny8_core`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, imem_addr is 0, bus_rd and bus_wr are 0, and every register reads as 0.
- R2: Cycles alternate fetch then execute, starting with fetch after reset. imem_addr holds the program counter through both cycles. bus_rd and bus_wr are only ever high in an execute cycle, and then for that single cycle.
- R3: The opcode is instruction bits [15:12], and the fields are A = [11:8], B = [7:4], C = [3:0], IMM = [7:0]. Opcodes 0 and 7 to 15 are no-ops: the counter advances by one and there is no bus activity.
- R4: Opcode 1 (SET) writes IMM into register A.
- R5: Opcode 2 (LOAD) asserts bus_rd with bus_addr = reg[B] + C modulo 256. It writes the bus_rdata sampled in that same cycle into register A.
- R6: Opcode 3 (STORE) asserts bus_wr with bus_addr = reg[B] + C modulo 256 and bus_wdata = reg[A]. No register changes.
- R7: Opcode 4 (ADD) writes (reg[B] + reg[C]) modulo 256 into register A.
- R8: Opcode 5 (BEQ) skips the next instruction when reg[A] equals IMM. Opcode 6 (BNEQ) skips the next instruction when they differ. A skip advances the counter by 2; otherwise the counter advances by 1.
- R9: An instruction that writes register 0 loads the written value into the program counter, and that value is the next fetch address. Reading register 0 as an operand gives the address of the current instruction.
- R10: Counter increments wrap modulo 256: from 255 a plain step goes to 0 and a taken skip goes to 1.
- R11: Outside a bus access, bus_addr and bus_wdata are 0. bus_rd and bus_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Instruction fetch address (program counter) |
| imem_data | input | 16 | Instruction word returned combinationally for imem_addr |
| bus_addr | output | 8 | Data bus byte address |
| bus_wdata | output | 8 | Data bus write byte |
| bus_rdata | input | 8 | Data bus read byte, sampled while bus_rd is high |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_wr | output | 1 | Single-cycle write strobe |

## Verification
The hardest situations to reach from the pins involve R0. A computed jump requires a LOAD or ADD whose destination is register 0, and an operand read of R0 must see the current instruction address; both depend on what earlier random instructions left in the registers. The bench fills the whole instruction store with random words biased toward the defined opcodes and runs thousands of instructions against an instruction-level model, so such cases recur many times. Directed programs separately force counter wrap from 255 with and without a taken skip, a computed ADD of R0 with itself, and a STORE of every register straight after reset.

// File: rtl/t8_pkg.sv
package t8_pkg;
  localparam int OPW = 4;
  localparam int FLDW = 4;
  localparam int IMMW = 8;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 4'd0,
    OP_SET   = 4'd1,
    OP_LOAD  = 4'd2,
    OP_STORE = 4'd3,
    OP_ADD   = 4'd4,
    OP_BEQ   = 4'd5,
    OP_BNEQ  = 4'd6
  } op_e;

  typedef struct packed {
    op_e             op;
    logic [FLDW-1:0] fa;
    logic [FLDW-1:0] fb;
    logic [FLDW-1:0] fc;
    logic [IMMW-1:0] imm;
    logic            writes;
  } dec_t;
endpackage

// File: rtl/t8_decode.sv
module t8_decode
  import t8_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic [IW-1:0] ir,
  output dec_t          dec
);
  localparam int OP_LSB = IW - OPW;

  logic [OPW-1:0] raw_op;

  always_comb begin
    raw_op     = ir[IW-1:OP_LSB];
    dec.fa     = ir[OP_LSB-1 -: FLDW];
    dec.fb     = ir[OP_LSB-FLDW-1 -: FLDW];
    dec.fc     = ir[FLDW-1:0];
    dec.imm    = ir[IMMW-1:0];
    case (raw_op)
      4'd1:    dec.op = OP_SET;
      4'd2:    dec.op = OP_LOAD;
      4'd3:    dec.op = OP_STORE;
      4'd4:    dec.op = OP_ADD;
      4'd5:    dec.op = OP_BEQ;
      4'd6:    dec.op = OP_BNEQ;
      default: dec.op = OP_NOP;
    endcase
    dec.writes = (dec.op == OP_SET) || (dec.op == OP_LOAD) || (dec.op == OP_ADD);
  end
endmodule

// File: rtl/t8_regfile.sv
module t8_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 16,
  parameter int NRD   = 3,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           wr_en,
  input  logic [RIW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_val,
  input  logic [DW-1:0]  pc_seq,
  input  logic [RIW-1:0] rd_idx [NRD],
  output logic [DW-1:0]  rd_val [NRD],
  output logic [DW-1:0]  pc
);
  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (step) begin
      regs[0] <= (wr_en && wr_idx == '0) ? wr_val : pc_seq;
      for (int i = 1; i < NREGS; i++)
        if (wr_en && wr_idx == RIW'(i)) regs[i] <= wr_val;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_val[p] = regs[rd_idx[p]];
  end

  assign pc = regs[0];
endmodule

// File: rtl/t8_exec.sv
module t8_exec
  import t8_pkg::*;
#(
  parameter int DW = 8
) (
  input  dec_t          dec,
  input  logic [DW-1:0] va,
  input  logic [DW-1:0] vb,
  input  logic [DW-1:0] vc,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wb_val,
  output logic          rd_req,
  output logic          wr_req,
  output logic          skip
);
  always_comb begin
    addr   = vb + DW'(dec.fc);
    rd_req = (dec.op == OP_LOAD);
    wr_req = (dec.op == OP_STORE);
    case (dec.op)
      OP_SET:  wb_val = DW'(dec.imm);
      OP_LOAD: wb_val = rdata;
      OP_ADD:  wb_val = vb + vc;
      default: wb_val = '0;
    endcase
    case (dec.op)
      OP_BEQ:  skip = (va == DW'(dec.imm));
      OP_BNEQ: skip = (va != DW'(dec.imm));
      default: skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
  import t8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREGS  = 16,
  parameter int INST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] imem_addr,
  input  logic [INST_W-1:0] imem_data,
  output logic [DATA_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr
);
  localparam int RIW = $clog2(NREGS);
  localparam int NRD = 3;

  logic              exec_q;
  logic [INST_W-1:0] ir_q;
  dec_t              dec;
  logic [RIW-1:0]    rd_idx [NRD];
  logic [DATA_W-1:0] rd_val [NRD];
  logic [DATA_W-1:0] pc, pc_seq, ex_addr, wb_val;
  logic              rd_req, wr_req, skip;
  logic              wb_en, pc_wr;

  // fetch / execute sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= 1'b0;
      ir_q   <= '0;
    end else begin
      exec_q <= !exec_q;
      if (!exec_q) ir_q <= imem_data;
    end
  end

  t8_decode #(.IW(INST_W)) u_dec (.ir(ir_q), .dec(dec));

  assign rd_idx[0] = RIW'(dec.fa);
  assign rd_idx[1] = RIW'(dec.fb);
  assign rd_idx[2] = RIW'(dec.fc);

  t8_exec #(.DW(DATA_W)) u_exe (
    .dec   (dec),
    .va    (rd_val[0]),
    .vb    (rd_val[1]),
    .vc    (rd_val[2]),
    .rdata (bus_rdata),
    .addr  (ex_addr),
    .wb_val(wb_val),
    .rd_req(rd_req),
    .wr_req(wr_req),
    .skip  (skip)
  );

  assign wb_en  = exec_q && dec.writes;
  assign pc_wr  = wb_en && (dec.fa == '0);
  assign pc_seq = pc + DATA_W'(skip ? 2 : 1);

  t8_regfile #(.DW(DATA_W), .NREGS(NREGS), .NRD(NRD)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (exec_q),
    .wr_en (wb_en),
    .wr_idx(RIW'(dec.fa)),
    .wr_val(wb_val),
    .pc_seq(pc_seq),
    .rd_idx(rd_idx),
    .rd_val(rd_val),
    .pc    (pc)
  );

  assign imem_addr = pc;
  assign bus_rd    = exec_q && rd_req;
  assign bus_wr    = exec_q && wr_req;
  assign bus_addr  = (bus_rd || bus_wr) ? ex_addr : '0;
  assign bus_wdata = bus_wr ? rd_val[0] : '0;
endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] imem_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       exec_q,
  input logic       pc_wr,
  input logic [7:0] wb_val
);
  assert_reset_pc_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (imem_addr == 8'd0 && !bus_rd && !bus_wr));

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> !(bus_rd || bus_wr));

  assert_strobe_exec_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_q |-> !(bus_rd || bus_wr));

  assert_pc_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |-> $stable(imem_addr));

  assert_no_dual_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && pc_wr) |=> (imem_addr == $past(wb_val)));

  assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_q && !pc_wr) |=> (imem_addr == $past(imem_addr) + 8'd1 ||
                            imem_addr == $past(imem_addr) + 8'd2));
endmodule

bind tiny8_core tiny8_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .imem_addr(imem_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .exec_q   (exec_q),
  .pc_wr    (pc_wr),
  .wb_val   (wb_val)
);

// File: tb/sim_tiny8_core.sv
module sim_tiny8_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr, bus_addr, bus_wdata, bus_rdata;
  logic [15:0] imem_data;
  logic        bus_rd, bus_wr;

  logic [15:0] rom  [256];
  logic [7:0]  dmem [256];
  logic [7:0]  m_r  [16];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  assign imem_data = rom[imem_addr];
  assign bus_rdata = dmem[bus_addr];
  always @(posedge clk) if (bus_wr) dmem[bus_addr] <= bus_wdata;

  tiny8_core u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int op, input int a, input int b, input int c);
    return {4'(op), 4'(a), 4'(b), 4'(c)};
  endfunction

  function automatic string req_of(input int op);
    case (op)
      1: return "R4 set";
      2: return "R5 load";
      3: return "R6 store";
      4: return "R7 add";
      5, 6: return "R8 skip";
      default: return "R3 nop";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) m_r[i] = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, 0);
    rst_n = 1'b1;
    chk("R1 pc after reset", imem_addr, 0);
    chk("R1 strobes after reset", {bus_rd, bus_wr}, 0);
  endtask

  // One instruction: called at the negedge of a fetch cycle, returns at the next fetch.
  task automatic step();
    logic [15:0] ir;
    int op, a, b, c;
    logic [7:0] addr, wb, nxt, pc;
    logic skip, wrt;
    string rq;
    pc = m_r[0];
    chk("R2 fetch addr", imem_addr, pc);
    chk("R2 no strobe in fetch", {bus_rd, bus_wr}, 0);
    @(negedge clk);
    ir = rom[pc];
    op = ir[15:12]; a = ir[11:8]; b = ir[7:4]; c = ir[3:0];
    if (op > 6) op = 0;
    rq = req_of(op);
    addr = m_r[b] + 8'(c);
    chk("R2 pc held in execute", imem_addr, pc);
    chk({rq, " rd"}, bus_rd, (op == 2) ? 1 : 0);
    chk({rq, " wr"}, bus_wr, (op == 3) ? 1 : 0);
    chk({rq, " R11 addr"}, bus_addr, (op == 2 || op == 3) ? addr : 0);
    chk({rq, " R11 wdata"}, bus_wdata, (op == 3) ? m_r[a] : 0);
    skip = 1'b0; wrt = 1'b0; wb = 8'd0;
    case (op)
      1: begin wrt = 1'b1; wb = ir[7:0]; end
      2: begin wrt = 1'b1; wb = dmem[addr]; end
      4: begin wrt = 1'b1; wb = m_r[b] + m_r[c]; end
      5: skip = (m_r[a] == ir[7:0]);
      6: skip = (m_r[a] != ir[7:0]);
      default: ;
    endcase
    nxt = pc + (skip ? 8'd2 : 8'd1);   // R10 wrap by 8-bit arithmetic
    if (wrt && a == 0) nxt = wb;        // R9 jump
    else if (wrt) m_r[a] = wb;
    m_r[0] = nxt;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) dmem[i] = 8'($urandom);

    // Directed: store every register right after reset (R1 register clear)
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    for (int i = 0; i < 15; i++) rom[i] = mk(3, i + 1, 2, i);
    do_reset();
    for (int i = 0; i < 15; i++) begin
      chk("R1 register clear", bus_wdata, 0);  // at fetch: zero outside access
      step();
    end
    for (int i = 1; i < 15; i++) chk("R1 R6 stored zero", dmem[i], 0);

    // Directed: jump, R0 operand, wrap from 255 (R9, R10)
    for (int i = 0; i < 256; i++) rom[i] = 16'hF123;   // undefined opcode -> NOP (R3)
    rom[0]   = mk(3, 7, 2, 4);
    rom[1]   = {4'd1, 4'd0, 8'd250};
    rom[250] = mk(4, 4, 0, 0);          // R4 = 250+250 mod 256 = 244
    rom[251] = mk(3, 4, 0, 1);          // store 244 at 252
    rom[253] = {4'd5, 4'd3, 8'd0};      // taken skip 253 -> 255
    rom[255] = {4'd5, 4'd3, 8'd0};      // taken skip 255 -> 1 (R10)
    do_reset();
    for (int i = 0; i < 14; i++) step();
    chk("R9 R7 computed R0 sum stored", dmem[252], 244);
    rom[255] = {4'd6, 4'd3, 8'd0};      // not taken: 255 -> 0 (R10)
    do_reset();
    for (int i = 0; i < 14; i++) step();

    // Random program against the model
    for (int i = 0; i < 256; i++)
      rom[i] = {4'($urandom % 8), 12'($urandom)};
    do_reset();
    for (int i = 0; i < 4000; i++) step();
    for (int i = 0; i < 256; i++)
      rom[i] = {4'(1 + $urandom % 6), 12'($urandom)};
    do_reset();
    for (int i = 0; i < 4000; i++) step();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule